// File: doc/BRIEF.md
# I2C Configuration Target with Strap Override

This block is a bus target for an I2C-compatible two-wire control bus. It samples the raw SCL and SDA levels in the system clock domain and serves a sixteen-entry, byte-wide register file. Its 7-bit bus address is looked up from a fixed table of four entries, using a 2-bit strap code. A build parameter chooses one of two address sets: one for the transmit-side link chip and one for the receive-side link chip. SDA is open-drain. The block only ever pulls it low through an output enable.

Entry 0x00 of the register file is a mode register. While it holds exactly 0x01, registers 0x01 upward drive the effective configuration outputs. For any other value, the strap/control pin inputs pass straight through to those outputs. After reset the block stays deaf to the bus for a hold-off time (10 ms by default). That time is derived from a clock-frequency parameter.

The first data byte of a write transfer sets the register pointer. Each later byte is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the pointer, and it goes on for as long as the master acknowledges.

Top module: `cfg_i2c_target`

## Requirements
- R1: After reset the mode register is 0x00, `sdaOe` is low, and `cfgEff` equals `strapCfg`.
- R2: Until HOLDOFF_MS milliseconds of clock cycles (at CLK_HZ) have passed since reset, the block never asserts `sdaOe`. A transfer whose START falls inside that window is not acknowledged.
- R3: The address for strap code 0,1,2,3 on `addrSel` is 0x69,0x6A,0x6B,0x6E when IS_DESER=0, and 0x71,0x72,0x73,0x76 when IS_DESER=1. A matching address byte (address in bits 7:1, direction in bit 0 with 1 = read) is acknowledged by pulling SDA low during the ninth clock.
- R4: An address byte that does not match leaves SDA released for the whole transfer, so the master sees a NACK.
- R5: In a write transfer, every data byte is acknowledged. The first byte loads the register pointer, and each later byte is stored at the pointer, which then increments.
- R6: `cfgEff` byte k (bits 8k+7:8k) equals register k+1 while register 0x00 holds exactly 0x01. For any other value of register 0x00, it equals the same byte of `strapCfg`.
- R7: A read transfer returns the register at the pointer, then further bytes at successive addresses for as long as the master acknowledges each one.
- R8: After a master NACK the block releases SDA and ignores the bus until the next START or repeated START.
- R9: Pointer values of 16 and above read as 0x00. Writes to them are acknowledged but change no register, including entry pointer mod 16.
- R10: A START or repeated START is SDA falling while SCL is high, and it restarts address reception. A STOP is SDA rising while SCL is high, and it returns the block to idle, so clocked bits without a new START get no acknowledge.
- R11: `sdaOe` only switches on while SCL is low, so the block never creates a START or a STOP on the bus itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Raw bus clock level |
| sda | input | 1 | Raw bus data level (wired bus) |
| addrSel | input | 2 | Strap code choosing the bus address |
| strapCfg | input | CFG_REGS*8 | Strap/control pin configuration |
| sdaOe | output | 1 | Pull SDA low when high |
| cfgEff | output | CFG_REGS*8 | Effective configuration |

## Verification
Two instances, one per address set, share one modelled open-drain bus. Every strap code is tried for both sets. Near-miss addresses (a neighbour in the same set, an address from the other set, an address outside both) tell exact matching apart from partial decoding. Multi-byte writes followed by reads with acknowledge, acknowledge, NACK show pointer loading, auto-increment and the point where the transfer ends. The mode register is written with 0x01, with 0x03 and with 0x00, and the strap inputs are also changed, which separates the override select from the register contents. Out-of-range pointers, bits clocked after a STOP, and a START issued inside the hold-off window expose aliasing, leftover state and early responses.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_CHK, S_ACK, S_WR, S_WR_CHK, S_RD, S_RD_ACK
  } busState_t;

  // strobes from the bus control to the register datapath
  typedef struct packed {
    logic       ptrLoad;
    logic       wrEn;
    logic       ptrInc;
    logic [7:0] data;
  } cfgStrobe_t;

  // four-entry address table; the last code sits apart from the other three
  function automatic logic [6:0] targetAddr(input logic deser, input logic [1:0] code);
    logic [6:0] base;
    base = deser ? 7'h70 : 7'h68;
    if (code == 2'd3) return base + 7'd6;
    return base + 7'd1 + {5'd0, code};
  endfunction

endpackage

// File: rtl/cfg_i2c_ctrl.sv
module cfg_i2c_ctrl
  import cfg_i2c_pkg::*;
#(
  parameter bit IS_DESER    = 1'b0,
  parameter int HOLD_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scl,
  input  logic       sda,
  input  logic [1:0] addrSel,
  input  logic [7:0] rdByte,
  output cfgStrobe_t strb,
  output logic       sdaOe
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] holdCnt;
  logic          ready;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            holdCnt <= '0;
    else if (holdCnt != HW'(HOLD_CYCLES)) holdCnt <= holdCnt + 1'b1;
  end
  assign ready = (holdCnt == HW'(HOLD_CYCLES));

  // two-flop synchronizers plus one history stage for edge detection
  logic [1:0] sclPipe, sdaPipe;
  logic       sclPrev, sdaPrev, sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= 2'b11;
      sdaPipe <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[0], scl};
      sdaPipe <= {sdaPipe[0], sda};
      sclPrev <= sclPipe[1];
      sdaPrev <= sdaPipe[1];
    end
  end
  assign sclS = sclPipe[1];
  assign sdaS = sdaPipe[1];

  logic sclRise, sclFall, startDet, stopDet;
  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftIn, rdShift;
  logic       isRead, firstByte, mAck;
  logic [6:0] myAddr;

  assign myAddr = targetAddr(IS_DESER, addrSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shiftIn   <= '0;
      rdShift   <= '0;
      isRead    <= 1'b0;
      firstByte <= 1'b0;
      mAck      <= 1'b0;
      sdaOe     <= 1'b0;
      strb      <= '0;
    end else begin
      strb      <= '0;
      strb.data <= shiftIn;
      if (!ready) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else if (startDet) begin
        state  <= S_ADDR;
        bitCnt <= '0;
        sdaOe  <= 1'b0;
      end else if (stopDet) begin
        state <= S_IDLE;
        sdaOe <= 1'b0;
      end else begin
        unique case (state)
          S_IDLE: ;
          S_ADDR, S_WR: begin
            if (sclRise) begin
              shiftIn <= {shiftIn[6:0], sdaS};
              if (bitCnt == 4'd7) state <= (state == S_ADDR) ? S_ADDR_CHK : S_WR_CHK;
              else                bitCnt <= bitCnt + 1'b1;
            end
          end
          S_ADDR_CHK: begin
            if (sclFall) begin
              if (shiftIn[7:1] == myAddr) begin
                sdaOe     <= 1'b1;
                isRead    <= shiftIn[0];
                firstByte <= 1'b1;
                state     <= S_ACK;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          S_WR_CHK: begin
            if (sclFall) begin
              sdaOe     <= 1'b1;
              state     <= S_ACK;
              firstByte <= 1'b0;
              if (firstByte) strb.ptrLoad <= 1'b1;
              else begin
                strb.wrEn   <= 1'b1;
                strb.ptrInc <= 1'b1;
              end
            end
          end
          S_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (isRead) begin
                rdShift <= rdByte;
                sdaOe   <= ~rdByte[7];
                state   <= S_RD;
              end else begin
                sdaOe <= 1'b0;
                state <= S_WR;
              end
            end
          end
          S_RD: begin
            if (sclRise) bitCnt <= bitCnt + 1'b1;
            if (sclFall) begin
              if (bitCnt == 4'd8) begin
                sdaOe       <= 1'b0;
                state       <= S_RD_ACK;
                strb.ptrInc <= 1'b1;
              end else begin
                sdaOe <= ~rdShift[3'd7 - bitCnt[2:0]];
              end
            end
          end
          S_RD_ACK: begin
            if (sclRise) mAck <= ~sdaS;
            if (sclFall) begin
              if (mAck) begin
                rdShift <= rdByte;
                sdaOe   <= ~rdByte[7];
                bitCnt  <= '0;
                state   <= S_RD;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  // R2: silent until the hold-off counter has run out
  p_quiet_holdoff_r2: assert property (@(posedge clk) disable iff (!rstN)
    !ready |-> !sdaOe);

  // R11: the pull-down only engages while the synchronized clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclS);

  // R4 / R8: a target that stays idle keeps SDA released
  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && $past(state) == S_IDLE) |-> !sdaOe);

  // R5: pointer load and register write never coincide
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ptrLoad, strb.wrEn}));

endmodule

// File: rtl/cfg_i2c_regs.sv
module cfg_i2c_regs
  import cfg_i2c_pkg::*;
#(
  parameter int REGS     = 16,
  parameter int CFG_REGS = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cfgStrobe_t            strb,
  input  logic [CFG_REGS*8-1:0] strapCfg,
  output logic [7:0]            rdByte,
  output logic [CFG_REGS*8-1:0] cfgEff
);

  localparam int AW = $clog2(REGS);

  logic [7:0] mem [REGS];
  logic [7:0] ptr;
  logic       inRange, override;

  assign inRange  = (ptr < 8'(REGS));
  assign override = (mem[0] == 8'h01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < REGS; i++) mem[i] <= '0;
    end else begin
      if (strb.ptrLoad)     ptr <= strb.data;
      else if (strb.ptrInc) ptr <= ptr + 1'b1;
      if (strb.wrEn && inRange) mem[ptr[AW-1:0]] <= strb.data;
    end
  end

  assign rdByte = inRange ? mem[ptr[AW-1:0]] : 8'h00;

  for (genvar k = 0; k < CFG_REGS; k++) begin : g_cfg
    assign cfgEff[k*8 +: 8] = override ? mem[k+1] : strapCfg[k*8 +: 8];
  end

  // R5: a write strobe lands the byte at the old pointer
  p_wr_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && inRange) |=> mem[$past(ptr[AW-1:0])] == $past(strb.data));

  // R7: an increment strobe advances the pointer by one
  p_ptr_inc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrLoad) |=> ptr == $past(ptr) + 8'd1);

  // R9: writes beyond the file leave the mode register alone
  p_oob_keep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !inRange) |=> $stable(mem[0]));

endmodule

// File: rtl/cfg_i2c_target.sv
module cfg_i2c_target
  import cfg_i2c_pkg::*;
#(
  parameter bit IS_DESER   = 1'b0,
  parameter int CLK_HZ     = 50000000,
  parameter int HOLDOFF_MS = 10,
  parameter int REGS       = 16,
  parameter int CFG_REGS   = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  scl,
  input  logic                  sda,
  input  logic [1:0]            addrSel,
  input  logic [CFG_REGS*8-1:0] strapCfg,
  output logic                  sdaOe,
  output logic [CFG_REGS*8-1:0] cfgEff
);

  localparam int HOLD_CYCLES = (CLK_HZ / 1000) * HOLDOFF_MS;

  cfgStrobe_t strb;
  logic [7:0] rdByte;

  cfg_i2c_ctrl #(.IS_DESER(IS_DESER), .HOLD_CYCLES(HOLD_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .scl(scl), .sda(sda), .addrSel(addrSel),
    .rdByte(rdByte), .strb(strb), .sdaOe(sdaOe)
  );

  cfg_i2c_regs #(.REGS(REGS), .CFG_REGS(CFG_REGS)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .strapCfg(strapCfg),
    .rdByte(rdByte), .cfgEff(cfgEff)
  );

endmodule

// File: tb/test_cfg_i2c_target.sv
module test_cfg_i2c_target;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 20;
  localparam int CLK_HZ     = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1, sdaM = 1'b1;
  logic [1:0]  addrSel = 2'd0;
  logic [31:0] strapCfg = 32'h1122_3344;
  logic        oeA, oeB;
  logic [31:0] cfgA, cfgB;
  logic        sdaBus;
  int          nChk = 0, nErr = 0, oeBadCnt = 0;
  bit          done = 1'b0;

  assign sdaBus = sdaM & ~oeA & ~oeB;
  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_i2c_target #(.IS_DESER(1'b0), .CLK_HZ(CLK_HZ)) i_cfg_i2c_target (
    .clk(clk), .rstN(rstN), .scl(sclM), .sda(sdaBus), .addrSel(addrSel),
    .strapCfg(strapCfg), .sdaOe(oeA), .cfgEff(cfgA));

  cfg_i2c_target #(.IS_DESER(1'b1), .CLK_HZ(CLK_HZ)) i_cfgDeser (
    .clk(clk), .rstN(rstN), .scl(sclM), .sda(sdaBus), .addrSel(addrSel),
    .strapCfg(strapCfg), .sdaOe(oeB), .cfgEff(cfgB));

  // R11 monitor: the pull-down must never engage while SCL is high
  logic oeAPrev = 1'b0, oeBPrev = 1'b0;
  always @(negedge clk) begin
    if (rstN && sclM && ((oeA && !oeAPrev) || (oeB && !oeBPrev))) oeBadCnt++;
    oeAPrev <= oeA;
    oeBPrev <= oeB;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    wt(5); sdaM = b; wt(HALF - 5); sclM = 1'b1; wt(HALF); sclM = 1'b0;
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; wt(HALF); sclM = 1'b1; wt(HALF/2); b = sdaBus; wt(HALF/2); sclM = 1'b0;
  endtask

  task automatic busStart();
    wt(5); sdaM = 1'b1; wt(5); sclM = 1'b1; wt(HALF); sdaM = 1'b0; wt(HALF); sclM = 1'b0;
  endtask

  task automatic busStop();
    wt(5); sdaM = 1'b0; wt(HALF - 5); sclM = 1'b1; wt(HALF); sdaM = 1'b1; wt(HALF);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) bitOut(b[i]);
    readBit(x);
    ack = ~x;
  endtask

  task automatic recvByte(input logic masterAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) readBit(b[i]);
    bitOut(~masterAck);
  endtask

  function automatic logic [6:0] serAddr(input int c);
    case (c) 0: return 7'h69; 1: return 7'h6A; 2: return 7'h6B; default: return 7'h6E; endcase
  endfunction

  function automatic logic [6:0] desAddr(input int c);
    case (c) 0: return 7'h71; 1: return 7'h72; 2: return 7'h73; default: return 7'h76; endcase
  endfunction

  task automatic regWrite(input logic [7:0] ptr, input logic [7:0] val, input string req);
    logic a;
    busStart();
    sendByte({7'h69, 1'b0}, a); check({req, " addr ack"}, a, 1);
    sendByte(ptr, a);           check({req, " ptr ack"}, a, 1);
    sendByte(val, a);           check({req, " data ack"}, a, 1);
    busStop();
  endtask

  task automatic regRead(input logic [7:0] ptr, output logic [7:0] val);
    logic a;
    busStart();
    sendByte({7'h69, 1'b0}, a);
    sendByte(ptr, a);
    busStart();
    sendByte({7'h69, 1'b1}, a);
    recvByte(1'b0, val);
    busStop();
  endtask

  task automatic tReset();
    check("R1 cfgEff follows strap", cfgA, strapCfg);
    check("R1 sdaOe idle", {oeB, oeA}, 0);
  endtask

  task automatic tHoldoff();
    logic a;
    busStart();
    sendByte({7'h69, 1'b0}, a);
    check("R2 no ack in hold-off", a, 0);
    busStop();
    wt(800);
  endtask

  task automatic tAddrTable();
    logic a;
    for (int c = 0; c < 4; c++) begin
      addrSel = 2'(c); wt(5);
      busStart(); sendByte({serAddr(c), 1'b0}, a); busStop();
      check($sformatf("R3 ser code %0d ack", c), a, 1);
      busStart(); sendByte({desAddr(c), 1'b0}, a); busStop();
      check($sformatf("R3 deser code %0d ack", c), a, 1);
    end
    addrSel = 2'd0; wt(5);
  endtask

  task automatic tMismatch();
    logic a;
    logic [6:0] bad [3] = '{7'h6A, 7'h6C, 7'h72};
    foreach (bad[i]) begin
      busStart(); sendByte({bad[i], 1'b0}, a);
      check($sformatf("R4 nack addr %h", bad[i]), a, 0);
      sendByte(8'h55, a);
      check("R4 no ack on data after nack", a, 0);
      busStop();
    end
  endtask

  task automatic tWriteAck();
    logic a;
    logic [7:0] vals [4] = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    busStart();
    sendByte({7'h69, 1'b0}, a); check("R5 addr ack", a, 1);
    sendByte(8'h01, a);         check("R5 pointer ack", a, 1);
    foreach (vals[i]) begin
      sendByte(vals[i], a);
      check($sformatf("R5 data byte %0d ack", i), a, 1);
    end
    busStop();
    check("R6 strap still drives in mode 0", cfgA, strapCfg);
  endtask

  task automatic tMode();
    regWrite(8'h00, 8'h01, "R6");
    check("R6 override on", cfgA, 32'hD4C3_B2A1);
    strapCfg = 32'h5566_7788; wt(5);
    check("R6 strap change ignored", cfgA, 32'hD4C3_B2A1);
    regWrite(8'h00, 8'h03, "R6");
    check("R6 non-01 selects strap", cfgA, 32'h5566_7788);
    regWrite(8'h00, 8'h01, "R6");
    check("R6 override again", cfgA, 32'hD4C3_B2A1);
    regWrite(8'h00, 8'h00, "R6");
    check("R6 back to strap", cfgA, 32'h5566_7788);
  endtask

  task automatic tRead();
    logic a, x;
    logic [7:0] b0, b1, b2;
    busStart();
    sendByte({7'h69, 1'b0}, a);
    sendByte(8'h01, a);
    busStart();
    sendByte({7'h69, 1'b1}, a); check("R7 read addr ack", a, 1);
    recvByte(1'b1, b0);
    recvByte(1'b1, b1);
    recvByte(1'b0, b2);
    check("R7 byte at pointer", b0, 8'hA1);
    check("R7 auto-increment 1", b1, 8'hB2);
    check("R7 auto-increment 2", b2, 8'hC3);
    readBit(x);
    check("R8 released after master nack", x, 1);
    busStop();
  endtask

  task automatic tUnimpl();
    logic [7:0] v;
    regWrite(8'h10, 8'h5A, "R9");
    regRead(8'h10, v);
    check("R9 out-of-range reads zero", v, 8'h00);
    regRead(8'h00, v);
    check("R9 no alias into entry 0", v, 8'h00);
    check("R9 config untouched", cfgA, 32'h5566_7788);
  endtask

  task automatic tStartStop();
    logic a;
    busStart();
    sendByte({7'h69, 1'b0}, a);
    sendByte(8'h02, a);
    busStop();
    sendByte({7'h69, 1'b0}, a);
    check("R10 no ack without start", a, 0);
    busStop();
    busStart();
    sendByte({7'h6C, 1'b0}, a);
    check("R10 wrong addr nack", a, 0);
    busStart();
    sendByte({7'h69, 1'b0}, a);
    check("R10 repeated start restarts address", a, 1);
    busStop();
  endtask

  initial begin
    wt(3);
    tReset();
    rstN = 1'b1;
    tHoldoff();
    tAddrTable();
    tMismatch();
    tWriteAck();
    tMode();
    tRead();
    tUnimpl();
    tStartStop();
    check("R11 pull-down only with SCL low", oeBadCnt, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++;
      nErr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule